// File: doc/BRIEF.md
# Trapezoidal Motion Setpoint Generator

This block feeds a position control loop with a desired-position setpoint. It advances the setpoint once per profile tick. A programmable divider makes those ticks from the system clock, so the divide ratio scales the effective velocity and acceleration. A start pulse captures the profile parameters and the present position of the axis. The setpoint then moves each tick by the current velocity, and the velocity ramps by a fixed acceleration step towards a cruise value.

Two modes are available. In velocity mode the ramp runs up to the cruise value and the axis keeps moving until a stop arrives. In position mode the block counts how many acceleration steps it took and adds up the distance they covered. When the distance left is no greater than that accumulated distance, it ramps down at the same rate for the same number of steps. It lands exactly on the target and raises a done flag.

The setpoint leaves the block as a stream with a one-cycle `sp_valid` strobe on every tick that moves it. The stream has no ready and no back-pressure. The consumer must take each value in the cycle its strobe is high. The output stays stable between strobes, so a late reader sees the last value.

Top module: `trap_setpoint_gen`

## Requirements
- R1: After reset, `setpoint` and `velocity` are 0, and `done` and `sp_valid` are low.
- R2: A cycle with `start` high and `stop` low loads `cur_pos` into `setpoint` and `v_start` into `velocity`, clears `done`, and starts the ramp-up at the next edge.
- R3: On each tick while running, `setpoint` moves by the pre-step `velocity`: added when the latched `dir_up` is 1, subtracted when it is 0, with 16-bit wrap. `sp_valid` is high for exactly the cycle after each such tick. Without a tick, `setpoint` does not change.
- R4: During ramp-up, each tick sets velocity to min(velocity + accel, v_end). Once it equals v_end, it holds there. In velocity mode (`mode_pos`=0) motion never ends by itself.
- R5: With `tick_en` high, a tick occurs every `tick_div`+1 cycles. The count is cleared by `start`, by `stop` and by `tick_en` low. No step happens while `tick_en` is low.
- R6: In position mode, a non-final tick in ramp-up or cruise enters ramp-down when the remaining distance after the step is no greater than the distance accumulated during ramp-up (including the current step). Velocity is kept unchanged on that tick.
- R7: During ramp-down, each tick lowers velocity by accel (with a floor of 1) for as many ticks as there were ramp-up iterations. After that, velocity holds.
- R8: In position mode, a tick whose velocity is at least the remaining distance (or whose remaining distance is not positive) sets `setpoint` to the latched end position and `velocity` to 0. `done` rises and holds with no further steps until the next start or stop.
- R9: `stop` has priority over `start`. It zeroes `velocity`, clears `done`, keeps `setpoint`, and stops all steps until the next start.
- R10: v_end, accel, end_pos, dir_up and mode_pos are captured on start. Changing those inputs later has no effect on the profile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Enables the profile tick divider |
| tick_div | input | 16 | Divide ratio minus one between profile ticks |
| start | input | 1 | Loads parameters and begins a profile |
| stop | input | 1 | Halts the profile and clears state |
| mode_pos | input | 1 | 1 = position mode, 0 = velocity mode |
| dir_up | input | 1 | 1 = setpoint increases, 0 = decreases |
| v_start | input | 8 | Initial velocity per tick |
| v_end | input | 8 | Cruise velocity per tick |
| accel | input | 8 | Velocity change per tick |
| end_pos | input | 16 | Target position for position mode |
| cur_pos | input | 16 | Present axis position, loaded on start |
| setpoint | output | 16 | Desired position |
| sp_valid | output | 1 | One-cycle strobe when setpoint has stepped |
| velocity | output | 8 | Current profile velocity |
| done | output | 1 | Target reached in position mode |

## Verification
The bench targets the transition into ramp-down and the exact landing on the target. A design that entered ramp-down one tick late or early would overshoot and clamp early, or crawl at velocity 1. A design with a wrong landing test would step past the target or stop short of it. Profiles that never reach cruise (triangular moves) and targets that lie behind the direction of travel are driven in, to catch wrong signed distance arithmetic. Tests for a stop arriving together with a start, changes to parameters mid-move, and divider ratios above zero expose a wrong priority, parameters that were not captured, and ticks that are off by one cycle.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACCEL  = 3'd1,
    ST_CRUISE = 3'd2,
    ST_DECEL  = 3'd3,
    ST_DONE   = 3'd4
  } prof_state_t;
endpackage

// File: rtl/tsg_tick_div.sv
module tsg_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr || !en || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R5: a tick is followed by a gap unless the ratio is zero
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && ratio != '0) |=> (!tick || ratio == '0));
endmodule

// File: rtl/tsg_dist_calc.sv
module tsg_dist_calc #(
  parameter int POS_W = 16,
  parameter int VEL_W = 8,
  localparam int RW   = POS_W + 2
) (
  input  logic [POS_W-1:0] sp,
  input  logic [POS_W-1:0] tgt,
  input  logic             dir_up,
  input  logic [VEL_W-1:0] vel,
  output logic             arrive,
  output logic [RW-1:0]    rem_after
);
  logic signed [RW-1:0] diff, rem, velx, after;

  assign diff      = $signed({2'b00, tgt}) - $signed({2'b00, sp});
  assign rem       = dir_up ? diff : -diff;
  assign velx      = $signed({{(RW-VEL_W){1'b0}}, vel});
  assign arrive    = (rem <= 0) || (velx >= rem);
  assign after     = rem - velx;
  assign rem_after = after;
endmodule

// File: rtl/tsg_vel_step.sv
module tsg_vel_step #(
  parameter int VEL_W = 8
) (
  input  logic [VEL_W-1:0] vel,
  input  logic [VEL_W-1:0] acc,
  input  logic [VEL_W-1:0] vend,
  output logic [VEL_W-1:0] vel_up,
  output logic [VEL_W-1:0] vel_dn,
  output logic             at_end
);
  logic [VEL_W:0] sum;

  assign sum    = {1'b0, vel} + {1'b0, acc};
  assign vel_up = (sum >= {1'b0, vend}) ? vend : sum[VEL_W-1:0];
  assign vel_dn = (vel > acc) ? (vel - acc) : VEL_W'(1);
  assign at_end = (vel_up == vend);
endmodule

// File: rtl/trap_setpoint_gen.sv
module trap_setpoint_gen
  import tsg_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int VEL_W = 8,
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [DIV_W-1:0] tick_div,
  input  logic             start,
  input  logic             stop,
  input  logic             mode_pos,
  input  logic             dir_up,
  input  logic [VEL_W-1:0] v_start,
  input  logic [VEL_W-1:0] v_end,
  input  logic [VEL_W-1:0] accel,
  input  logic [POS_W-1:0] end_pos,
  input  logic [POS_W-1:0] cur_pos,
  output logic [POS_W-1:0] setpoint,
  output logic             sp_valid,
  output logic [VEL_W-1:0] velocity,
  output logic             done
);
  localparam int DIST_W = POS_W + 1;
  localparam int RW     = POS_W + 2;
  localparam logic [DIST_W-1:0] DIST_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  prof_state_t      st_q, st_d;
  logic [POS_W-1:0] sp_q, sp_d, sp_step, tgt_q;
  logic [VEL_W-1:0] vel_q, vel_d, vend_q, acc_q;
  logic [CNT_W-1:0] iter_q, iter_d, iter_inc;
  logic [DIST_W-1:0] dist_q, dist_d, dist_acc;
  logic [DIST_W:0]  dist_sum;
  logic             dir_q, posm_q, done_q, done_d, valid_q, valid_d;
  logic             tick, arrive, at_end, running;
  logic [RW-1:0]    rem_after;
  logic [VEL_W-1:0] vel_up, vel_dn;

  tsg_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(start | stop), .en(tick_en),
    .ratio(tick_div), .tick(tick)
  );

  tsg_dist_calc #(.POS_W(POS_W), .VEL_W(VEL_W)) u_dist (
    .sp(sp_q), .tgt(tgt_q), .dir_up(dir_q), .vel(vel_q),
    .arrive(arrive), .rem_after(rem_after)
  );

  tsg_vel_step #(.VEL_W(VEL_W)) u_vel (
    .vel(vel_q), .acc(acc_q), .vend(vend_q),
    .vel_up(vel_up), .vel_dn(vel_dn), .at_end(at_end)
  );

  assign running  = (st_q == ST_ACCEL) || (st_q == ST_CRUISE) || (st_q == ST_DECEL);
  assign sp_step  = dir_q ? (sp_q + {{(POS_W-VEL_W){1'b0}}, vel_q})
                          : (sp_q - {{(POS_W-VEL_W){1'b0}}, vel_q});
  assign dist_sum = {1'b0, dist_q} + {{(DIST_W+1-VEL_W){1'b0}}, vel_q};
  assign dist_acc = dist_sum[DIST_W] ? DIST_MAX : dist_sum[DIST_W-1:0];
  assign iter_inc = (iter_q == CNT_MAX) ? iter_q : iter_q + 1'b1;

  always_comb begin
    st_d    = st_q;
    sp_d    = sp_q;
    vel_d   = vel_q;
    iter_d  = iter_q;
    dist_d  = dist_q;
    done_d  = done_q;
    valid_d = 1'b0;
    if (stop) begin
      st_d   = ST_IDLE;
      vel_d  = '0;
      iter_d = '0;
      dist_d = '0;
      done_d = 1'b0;
    end else if (start) begin
      st_d   = ST_ACCEL;
      sp_d   = cur_pos;
      vel_d  = v_start;
      iter_d = '0;
      dist_d = '0;
      done_d = 1'b0;
    end else if (tick && running) begin
      valid_d = 1'b1;
      if (posm_q && arrive) begin
        sp_d   = tgt_q;
        vel_d  = '0;
        done_d = 1'b1;
        st_d   = ST_DONE;
      end else begin
        sp_d = sp_step;
        case (st_q)
          ST_ACCEL: begin
            iter_d = iter_inc;
            dist_d = dist_acc;
            vel_d  = vel_up;
            if (at_end) st_d = ST_CRUISE;
          end
          ST_DECEL: begin
            if (iter_q != '0) begin
              vel_d  = vel_dn;
              iter_d = iter_q - 1'b1;
            end
          end
          default: ;
        endcase
        if (posm_q && st_q != ST_DECEL && rem_after <= {1'b0, dist_d}) begin
          st_d  = ST_DECEL;
          vel_d = vel_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sp_q    <= '0;
      vel_q   <= '0;
      iter_q  <= '0;
      dist_q  <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      vend_q  <= '0;
      acc_q   <= '0;
      tgt_q   <= '0;
      dir_q   <= 1'b0;
      posm_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      sp_q    <= sp_d;
      vel_q   <= vel_d;
      iter_q  <= iter_d;
      dist_q  <= dist_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      if (start && !stop) begin
        vend_q <= v_end;
        acc_q  <= accel;
        tgt_q  <= end_pos;
        dir_q  <= dir_up;
        posm_q <= mode_pos;
      end
    end
  end

  assign setpoint = sp_q;
  assign velocity = vel_q;
  assign done     = done_q;
  assign sp_valid = valid_q;

  // R2: start loads position and initial velocity
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (sp_q == $past(cur_pos) && vel_q == $past(v_start) && !done_q));
  // R3: no tick, no start, no stop -> setpoint holds and no strobe
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start && !stop) |=> ($stable(sp_q) && !valid_q));
  // R4: cruising velocity equals the captured cruise value
  p_cruise_vel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CRUISE) |-> (vel_q == vend_q));
  // R7: ramp-down never raises velocity
  p_decel_nonrise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DECEL && tick && !start && !stop) |=> (vel_q <= $past(vel_q)));
  // R8: done implies zero velocity on target
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (vel_q == '0 && sp_q == tgt_q));
  // R9: stop clears velocity and done, keeps setpoint
  p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (vel_q == '0 && !done_q && $stable(sp_q)));
endmodule

// File: tb/trap_setpoint_gen_bench.sv
`timescale 1ns/1ps
module trap_setpoint_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] tick_div = '0;
  logic        start = 1'b0, stop = 1'b0, mode_pos = 1'b0, dir_up = 1'b0;
  logic [7:0]  v_start = '0, v_end = '0, accel = '0;
  logic [15:0] end_pos = '0, cur_pos = '0;
  logic [15:0] setpoint;
  logic        sp_valid, done;
  logic [7:0]  velocity;

  always #2.5 clk = ~clk;

  trap_setpoint_gen u_trap_setpoint_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_div(tick_div),
    .start(start), .stop(stop), .mode_pos(mode_pos), .dir_up(dir_up),
    .v_start(v_start), .v_end(v_end), .accel(accel), .end_pos(end_pos),
    .cur_pos(cur_pos), .setpoint(setpoint), .sp_valid(sp_valid),
    .velocity(velocity), .done(done)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  string ctx = "R1";

  // reference model state (0 idle,1 accel,2 cruise,3 decel,4 done)
  int m_st = 0, m_sp = 0, m_vel = 0, m_iter = 0, m_dist = 0, m_cnt = 0;
  int m_vend = 0, m_acc = 0, m_tgt = 0;
  bit m_dir = 0, m_pos = 0, m_done = 0, m_valid = 0;

  function automatic int vmin(int a, int b); return (a < b) ? a : b; endfunction

  task automatic model_edge();
    bit tk;
    int rem, rem2, nv, nd, ni, ns;
    tk = tick_en && (m_cnt == tick_div);
    if (start || stop || !tick_en || tk) m_cnt = 0; else m_cnt = (m_cnt + 1) & 16'hFFFF;
    m_valid = 0;
    if (stop) begin
      m_st = 0; m_vel = 0; m_iter = 0; m_dist = 0; m_done = 0;
    end else if (start) begin
      m_st = 1; m_sp = cur_pos; m_vel = v_start; m_iter = 0; m_dist = 0; m_done = 0;
      m_vend = v_end; m_acc = accel; m_tgt = end_pos; m_dir = dir_up; m_pos = mode_pos;
    end else if (tk && m_st >= 1 && m_st <= 3) begin
      m_valid = 1;
      rem = m_dir ? (m_tgt - m_sp) : (m_sp - m_tgt);
      if (m_pos && (rem <= 0 || m_vel >= rem)) begin
        m_sp = m_tgt; m_vel = 0; m_done = 1; m_st = 4;
      end else begin
        rem2 = rem - m_vel;
        nv = m_vel; nd = m_dist; ni = m_iter; ns = m_st;
        if (m_st == 1) begin
          ni = (m_iter == 65535) ? m_iter : m_iter + 1;
          nd = vmin(m_dist + m_vel, 131071);
          nv = vmin(m_vel + m_acc, m_vend);
          if (nv == m_vend) ns = 2;
        end else if (m_st == 3 && m_iter != 0) begin
          nv = (m_vel > m_acc) ? m_vel - m_acc : 1;
          ni = m_iter - 1;
        end
        if (m_pos && m_st != 3 && rem2 <= nd) begin ns = 3; nv = m_vel; end
        m_sp = (m_dir ? m_sp + m_vel : m_sp - m_vel) & 16'hFFFF;
        m_vel = nv; m_dist = nd; m_iter = ni; m_st = ns;
      end
    end
  endtask

  task automatic check(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", ctx, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check("setpoint", setpoint, m_sp);
    check("velocity", velocity, m_vel);
    check("done", done, m_done);
    check("sp_valid", sp_valid, m_valid);
  endtask

  // inputs are already set at a falling edge; advance one cycle and compare
  task automatic step();
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic go(bit pos, bit up, int vs, int ve, int ac, int cp, int ep, int dv);
    mode_pos = pos; dir_up = up; v_start = vs[7:0]; v_end = ve[7:0]; accel = ac[7:0];
    cur_pos = cp[15:0]; end_pos = ep[15:0]; tick_div = dv[15:0];
    start = 1; step(); start = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_to_done(int lim);
    for (int i = 0; i < lim && !m_done; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    ctx = "R1"; compare_all();
    tick_en = 1;
    run(3);

    ctx = "R2"; go(0, 1, 2, 10, 3, 100, 0, 0);
    check("R2 load setpoint", setpoint, 100);
    check("R2 load velocity", velocity, 2);
    ctx = "R4"; run(12);
    check("R4 cruise velocity", velocity, 10);
    check("R4 no done in velocity mode", done, 0);

    ctx = "R3"; go(0, 0, 5, 5, 0, 50000, 0, 0);
    run(10);
    check("R3 decreasing setpoint", setpoint, 50000 - 50);

    ctx = "R5"; go(0, 1, 1, 4, 1, 0, 0, 3);
    run(25);
    tick_en = 0; run(10); tick_en = 1; run(10);

    ctx = "R10"; go(1, 1, 1, 8, 1, 1000, 1400, 0);
    v_end = 200; accel = 50; end_pos = 9; dir_up = 0; mode_pos = 0;
    run_to_done(400);
    check("R10 captured target reached", setpoint, 1400);

    ctx = "R9"; go(0, 1, 3, 9, 2, 7000, 0, 1);
    run(9);
    stop = 1; start = 1; step(); stop = 0; start = 0;
    check("R9 velocity zero after stop", velocity, 0);
    run(8);

    ctx = "R6"; go(1, 1, 1, 20, 2, 1000, 1500, 0);
    ctx = "R7"; run_to_done(500);
    ctx = "R8";
    check("R8 done raised", done, 1);
    check("R8 landed on target", setpoint, 1500);
    run(6);
    check("R8 done held", done, 1);

    ctx = "R6"; go(1, 0, 0, 100, 3, 3000, 2900, 1);   // triangular move
    run_to_done(500);
    check("R6 triangular landing", setpoint, 2900);

    ctx = "R8"; go(1, 1, 4, 9, 1, 500, 400, 0);        // target behind travel
    run(2);
    check("R8 behind target clamps", setpoint, 400);
    check("R8 behind target done", done, 1);

    ctx = "R3";
    for (int r = 0; r < 30; r++) begin
      int cp, d, ve, vs, ac, dv;
      bit up, pos;
      pos = $urandom_range(0, 3) != 0;
      up  = $urandom_range(0, 1);
      cp  = 20000 + $urandom_range(0, 20000);
      d   = $urandom_range(0, 3000);
      vs  = $urandom_range(0, 7);
      ve  = $urandom_range(1, 60);
      ac  = $urandom_range(1, 5);
      dv  = $urandom_range(0, 2);
      go(pos, up, vs, ve, ac, cp, up ? cp + d : cp - d, dv);
      for (int i = 0; i < 2500 && !(pos && m_done); i++) begin
        tick_en = ($urandom_range(0, 9) != 0);
        stop = ($urandom_range(0, 499) == 0);
        step();
        stop = 0;
        if (!pos && i > 150) break;
      end
      tick_en = 1;
      run(3);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule